// File: doc/BRIEF.md
# Multichannel DMA control and status register block

This block is the software-visible control and status store for a peripheral DMA with up to sixteen channels. It sits between a simple single-access register port and the per-channel data movers. Software uses it to freeze or abort channels, to load each channel's command pointer, and to start work by adding to a per-channel semaphore. The channel engines report back through three pulse inputs: completion, termination and bus fault. The block latches these as sticky flags, qualifies them into a per-channel error vector, and drives one combined interrupt. The interrupt comes with an index that identifies the most urgent pending source.

Each shared register appears at three addresses. A write to the base address overwrites the register. A write to the alias at base+4 sets the bits given by ones in the data. A write to the alias at base+8 clears those bits. A read of any of the three returns the register value. With this scheme an interrupt handler acknowledges status by writing back exactly the bits it read, and no read-modify-write is needed.

Top module: `dmacsr_top`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `irq_src`, `freeze`, `chan_reset`, `run` and `err_vec` are all zero.
- R2: The completion register sits at 0x010 and holds completion flags in bits 0..15 and interrupt enables in bits 16..31. A write to 0x010 overwrites it, a write to 0x014 ORs data into it, and a write to 0x018 clears the bits that are one in the data. A read of 0x014 or 0x018 returns the register value.
- R3: A `cmp_pulse[i]` sets completion flag i. If a clear-alias write to that flag falls in the same cycle as the pulse, the flag stays set.
- R4: The error register sits at 0x020 with the same alias scheme. `term_pulse[i]` sets bit i. `bus_fault_pulse[i]` sets both bit i and bit 16+i.
- R5: `err_vec[i]` is high when bits i and 16+i of the error register are both set. It is also high when bit i is set, bit 16+i is clear and completion flag i is clear. Otherwise it is low.
- R6: `irq` is high exactly when some completion flag is set together with its enable, or some `err_vec` bit is high.
- R7: `irq_src` names the highest pending source. An error on channel i has code 16+i and an enabled completion on channel i has code i. Any error outranks every completion. The output is 0 when `irq` is low.
- R8: The channel control register sits at 0x030 with the same alias scheme. Bit i drives `freeze[i]` and bit 16+i drives `chan_reset[i]`.
- R9: If reset bit 16+i is set and `chan_idle[i]` is high at a clock edge with no control write in that cycle, the bit reads zero after that edge.
- R10: The command pointer of channel i is a 32-bit read/write register at 0x110 + i*0x70. Its value drives `cmd_ptr[32*i +: 32]` and a channel reset does not change it.
- R11: The semaphore of channel i sits at 0x140 + i*0x70 and reads back in bits 7..0. A write adds bits 7..0 of the data to the count, saturating at 255. A `sem_dec[i]` pulse subtracts one when the count is nonzero. `run[i]` is high while the count is nonzero.
- R12: While `chan_reset[i]` is high, the semaphore of channel i is forced to zero on the next edge and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase; writes take effect on the edge where psel, penable and pwrite are high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW (12) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational while psel is high and pwrite is low |
| cmp_pulse | input | NCH (16) | Per-channel completion pulse |
| term_pulse | input | NCH | Per-channel termination pulse |
| bus_fault_pulse | input | NCH | Per-channel bus fault pulse |
| sem_dec | input | NCH | Per-channel semaphore decrement from the engine |
| chan_idle | input | NCH | Per-channel idle indication from the engine |
| freeze | output | NCH | Per-channel freeze (pause) request |
| chan_reset | output | NCH | Per-channel abort request |
| run | output | NCH | Semaphore nonzero, channel may proceed |
| cmd_ptr | output | NCH*32 | Command pointers, channel i in bits 32*i+31..32*i |
| err_vec | output | NCH | Qualified per-channel error |
| irq | output | 1 | Combined interrupt |
| irq_src | output | 5 | Highest pending interrupt source |

## Verification
The hardware and software paths can both act on a status flag in the same cycle. The bench provokes this by driving a completion pulse in the same clock as a clear-alias write to that flag, then reads the flag back and expects it still set. A second such case is a completion and a termination arriving together on one channel. The bench sweeps every combination of completion, termination and bus fault over all sixteen channels. It judges the error register, `err_vec`, `irq` and `irq_src` against values it works out from the qualification rule. Semaphore updates are also checked while a channel abort is pending.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
    localparam int HALF      = 16;
    localparam int SRC_W     = $clog2(2 * HALF);
    localparam int DONE_BASE = 'h010;
    localparam int FAULT_BASE= 'h020;
    localparam int CTRL_BASE = 'h030;
    localparam int PTR_BASE  = 'h110;
    localparam int SEM_BASE  = 'h140;
    localparam int CH_STRIDE = 'h070;
    localparam int SET_OFS   = 4;
    localparam int CLR_OFS   = 8;

    typedef enum logic [1:0] {ACC_NONE, ACC_WR, ACC_SET, ACC_CLR} acc_e;

    function automatic logic [31:0] apply_acc(acc_e k, logic [31:0] old, logic [31:0] d);
        case (k)
            ACC_WR:  return d;
            ACC_SET: return old | d;
            ACC_CLR: return old & ~d;
            default: return old;
        endcase
    endfunction
endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
    import dmacsr_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    output acc_e          acc_done,
    output acc_e          acc_fault,
    output acc_e          acc_ctrl,
    output logic          rsel_done,
    output logic          rsel_fault,
    output logic          rsel_ctrl
);
    function automatic acc_e alias_of(logic [AW-1:0] a, int base);
        if (a == AW'(base))                 return ACC_WR;
        else if (a == AW'(base + SET_OFS))  return ACC_SET;
        else if (a == AW'(base + CLR_OFS))  return ACC_CLR;
        else                                return ACC_NONE;
    endfunction

    logic wr, rd;
    acc_e k_done, k_fault, k_ctrl;

    always_comb begin
        wr         = psel & penable & pwrite;
        rd         = psel & ~pwrite;
        k_done     = alias_of(paddr, DONE_BASE);
        k_fault    = alias_of(paddr, FAULT_BASE);
        k_ctrl     = alias_of(paddr, CTRL_BASE);
        acc_done   = wr ? k_done  : ACC_NONE;
        acc_fault  = wr ? k_fault : ACC_NONE;
        acc_ctrl   = wr ? k_ctrl  : ACC_NONE;
        rsel_done  = rd && (k_done  != ACC_NONE);
        rsel_fault = rd && (k_fault != ACC_NONE);
        rsel_ctrl  = rd && (k_ctrl  != ACC_NONE);
    end
endmodule

// File: rtl/dmacsr_chan.sv
module dmacsr_chan #(
    parameter int AW       = 12,
    parameter int SEMW     = 8,
    parameter int PTR_ADDR = 'h110,
    parameter int SEM_ADDR = 'h140
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic          hold_rst,
    input  logic          dec,
    output logic [31:0]   ptr_o,
    output logic          run_o,
    output logic [31:0]   rdata_o
);
    typedef struct packed {
        logic [31:0]     ptr;
        logic [SEMW-1:0] cnt;
    } cs_t;

    cs_t s_d, s_q;
    logic            hit_ptr, hit_sem;
    logic [SEMW-1:0] base_cnt;
    logic [SEMW:0]   sum;

    always_comb begin
        hit_ptr  = (addr == AW'(PTR_ADDR));
        hit_sem  = (addr == AW'(SEM_ADDR));
        s_d      = s_q;
        if (wr_en && hit_ptr) s_d.ptr = wdata;
        base_cnt = s_q.cnt - SEMW'(dec && (s_q.cnt != '0));
        sum      = {1'b0, base_cnt} + ((wr_en && hit_sem) ? {1'b0, wdata[SEMW-1:0]} : '0);
        s_d.cnt  = sum[SEMW] ? '1 : sum[SEMW-1:0];
        if (hold_rst) s_d.cnt = '0;
        rdata_o  = '0;
        if (rd_en && hit_ptr)      rdata_o = s_q.ptr;
        else if (rd_en && hit_sem) rdata_o[SEMW-1:0] = s_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr_o = s_q.ptr;
    assign run_o = (s_q.cnt != '0);
endmodule

// File: rtl/dmacsr_pick.sv
module dmacsr_pick
    import dmacsr_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0]   cmp_pend,
    input  logic [NCH-1:0]   err_pend,
    output logic             irq,
    output logic [SRC_W-1:0] src
);
    always_comb begin
        src = '0;
        for (int i = 0; i < NCH; i++)
            if (cmp_pend[i]) src = SRC_W'(i);
        for (int i = 0; i < NCH; i++)
            if (err_pend[i]) src = SRC_W'(HALF + i);
        irq = (|cmp_pend) | (|err_pend);
    end
endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
    import dmacsr_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int AW   = 12,
    parameter int SEMW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [AW-1:0]     paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NCH-1:0]    cmp_pulse,
    input  logic [NCH-1:0]    term_pulse,
    input  logic [NCH-1:0]    bus_fault_pulse,
    input  logic [NCH-1:0]    sem_dec,
    input  logic [NCH-1:0]    chan_idle,
    output logic [NCH-1:0]    freeze,
    output logic [NCH-1:0]    chan_reset,
    output logic [NCH-1:0]    run,
    output logic [NCH*32-1:0] cmd_ptr,
    output logic [NCH-1:0]    err_vec,
    output logic              irq,
    output logic [SRC_W-1:0]  irq_src
);
    typedef struct packed {
        logic [NCH-1:0] done;
        logic [NCH-1:0] en;
        logic [NCH-1:0] term;
        logic [NCH-1:0] bus;
        logic [NCH-1:0] frz;
        logic [NCH-1:0] rstr;
    } csr_t;

    csr_t st_d, st_q;
    acc_e acc_done, acc_fault, acc_ctrl;
    logic rsel_done, rsel_fault, rsel_ctrl;
    logic wr_en, rd_en;
    logic [31:0] w_done, w_fault, w_ctrl, n_done, n_fault, n_ctrl, ch_or;
    logic [31:0] ch_rd [NCH];

    dmacsr_decode #(.AW(AW)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .acc_done(acc_done), .acc_fault(acc_fault), .acc_ctrl(acc_ctrl),
        .rsel_done(rsel_done), .rsel_fault(rsel_fault), .rsel_ctrl(rsel_ctrl)
    );

    assign wr_en = psel & penable & pwrite;
    assign rd_en = psel & ~pwrite;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            dmacsr_chan #(
                .AW(AW), .SEMW(SEMW),
                .PTR_ADDR(PTR_BASE + i * CH_STRIDE),
                .SEM_ADDR(SEM_BASE + i * CH_STRIDE)
            ) u_ch (
                .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                .addr(paddr), .wdata(pwdata), .hold_rst(st_q.rstr[i]),
                .dec(sem_dec[i]), .ptr_o(cmd_ptr[32*i +: 32]),
                .run_o(run[i]), .rdata_o(ch_rd[i])
            );
        end
    endgenerate

    always_comb begin
        // register views as software sees them
        w_done  = '0; w_done[NCH-1:0]  = st_q.done; w_done[HALF +: NCH]  = st_q.en;
        w_fault = '0; w_fault[NCH-1:0] = st_q.term; w_fault[HALF +: NCH] = st_q.bus;
        w_ctrl  = '0; w_ctrl[NCH-1:0]  = st_q.frz;  w_ctrl[HALF +: NCH]  = st_q.rstr & ~chan_idle;

        n_done  = apply_acc(acc_done,  w_done,  pwdata);
        n_fault = apply_acc(acc_fault, w_fault, pwdata);
        n_ctrl  = apply_acc(acc_ctrl,  w_ctrl,  pwdata);

        st_d      = st_q;
        st_d.done = n_done[NCH-1:0] | cmp_pulse;
        st_d.en   = n_done[HALF +: NCH];
        st_d.term = n_fault[NCH-1:0] | term_pulse | bus_fault_pulse;
        st_d.bus  = n_fault[HALF +: NCH] | bus_fault_pulse;
        st_d.frz  = n_ctrl[NCH-1:0];
        st_d.rstr = n_ctrl[HALF +: NCH];

        err_vec = (st_q.term & st_q.bus) | (st_q.term & ~st_q.bus & ~st_q.done);

        ch_or = '0;
        for (int i = 0; i < NCH; i++) ch_or = ch_or | ch_rd[i];
        if (rsel_done)       prdata = w_done;
        else if (rsel_fault) prdata = w_fault;
        else if (rsel_ctrl) begin
            prdata = '0;
            prdata[NCH-1:0]   = st_q.frz;
            prdata[HALF +: NCH] = st_q.rstr;
        end
        else                 prdata = ch_or;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign freeze     = st_q.frz;
    assign chan_reset = st_q.rstr;

    dmacsr_pick #(.NCH(NCH)) u_pick (
        .cmp_pend(st_q.done & st_q.en), .err_pend(err_vec),
        .irq(irq), .src(irq_src)
    );
endmodule

// File: rtl/dmacsr_chk.sv
module dmacsr_chk
    import dmacsr_pkg::*;
#(
    parameter int NCH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_any,
    input logic [NCH-1:0]   cmp_p,
    input logic [NCH-1:0]   fault_p,
    input logic [NCH-1:0]   en,
    input logic [NCH-1:0]   chan_reset,
    input logic [NCH-1:0]   chan_idle,
    input logic [NCH-1:0]   run,
    input logic [NCH-1:0]   err_vec,
    input logic             irq,
    input logic [SRC_W-1:0] irq_src
);
    // R6
    cmp_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(cmp_p & en)) && !wr_any) |=> irq);

    // R4
    fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_p) |=> ((err_vec & $past(fault_p)) == $past(fault_p)));

    // R9
    rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(chan_reset & chan_idle)) && !wr_any) |=> ((chan_reset & $past(chan_reset & chan_idle)) == '0));

    // R12
    sem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_reset) |=> ((run & $past(chan_reset)) == '0));

    // R7
    src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_src == '0));
endmodule

bind dmacsr_top dmacsr_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_any(psel & penable & pwrite),
    .cmp_p(cmp_pulse), .fault_p(bus_fault_pulse), .en(st_q.en),
    .chan_reset(chan_reset), .chan_idle(chan_idle), .run(run),
    .err_vec(err_vec), .irq(irq), .irq_src(irq_src)
);

// File: tb/dmacsr_top_tb.sv
`timescale 1ns/1ps
module dmacsr_top_tb;
    localparam int NCH = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic [NCH-1:0] cmp_pulse = '0, term_pulse = '0, bus_fault_pulse = '0, sem_dec = '0, chan_idle = '0;
    logic [NCH-1:0] freeze, chan_reset, run, err_vec;
    logic [NCH*32-1:0] cmd_ptr;
    logic irq;
    logic [4:0] irq_src;
    int n_vec = 0, n_bad = 0;

    always #2 clk = ~clk;

    dmacsr_top u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cmp_pulse(cmp_pulse), .term_pulse(term_pulse), .bus_fault_pulse(bus_fault_pulse),
        .sem_dec(sem_dec), .chan_idle(chan_idle), .freeze(freeze), .chan_reset(chan_reset),
        .run(run), .cmd_ptr(cmd_ptr), .err_vec(err_vec), .irq(irq), .irq_src(irq_src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 1; pwrite = 0; paddr = a;
        #1 d = prdata;
        psel = 0; penable = 0;
    endtask

    task automatic pulse(input logic [NCH-1:0] c, input logic [NCH-1:0] t,
                         input logic [NCH-1:0] f, input logic [NCH-1:0] dc);
        @(negedge clk);
        cmp_pulse = c; term_pulse = t; bus_fault_pulse = f; sem_dec = dc;
        @(negedge clk);
        cmp_pulse = '0; term_pulse = '0; bus_fault_pulse = '0; sem_dec = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        bus_rd(12'h010, r); chk("R1 done reg", r, 0);
        bus_rd(12'h020, r); chk("R1 fault reg", r, 0);
        bus_rd(12'h030, r); chk("R1 ctrl reg", r, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 irq_src", {27'b0, irq_src}, 0);
        chk("R1 outputs", {freeze, run}, 0);
        chk("R1 err/reset", {err_vec, chan_reset}, 0);

        // R2 alias behaviour
        bus_wr(12'h010, 32'h00F0_0000); bus_rd(12'h010, r); chk("R2 base write", r, 32'h00F0_0000);
        bus_wr(12'h014, 32'h0F00_0000); bus_rd(12'h014, r); chk("R2 set alias", r, 32'h0FF0_0000);
        bus_wr(12'h018, 32'h0030_0000); bus_rd(12'h018, r); chk("R2 clear alias", r, 32'h0FC0_0000);

        // R6 masked completion
        bus_wr(12'h010, 32'h0);
        pulse(16'h0080, 0, 0, 0);
        chk("R6 masked irq", {31'b0, irq}, 0);
        bus_wr(12'h014, 32'h0080_0000);
        chk("R6 enabled irq", {31'b0, irq}, 1);
        chk("R7 src completion", {27'b0, irq_src}, 7);

        // R3 hardware set beats software clear in the same cycle
        bus_wr(12'h010, 32'hFFFF_0000);
        @(negedge clk);
        cmp_pulse = 16'h0020; psel = 1; penable = 1; pwrite = 1; paddr = 12'h018; pwdata = 32'h20;
        @(negedge clk);
        cmp_pulse = '0; psel = 0; penable = 0; pwrite = 0;
        bus_rd(12'h010, r); chk("R3 set wins", r, 32'hFFFF_0020);
        bus_wr(12'h018, 32'h20);
        bus_rd(12'h010, r); chk("R3 plain clear", r, 32'hFFFF_0000);

        // R4 R5 R6 R7 sweep: every channel, every pulse combination
        for (int i = 0; i < NCH; i++) begin
            for (int c = 0; c < 8; c++) begin
                logic d, t, b, e;
                logic [31:0] ef;
                d = c[0]; t = c[1]; b = c[2];
                bus_wr(12'h010, 32'hFFFF_0000);
                bus_wr(12'h028, 32'hFFFF_FFFF);
                pulse(16'(d) << i, 16'(t) << i, 16'(b) << i, 0);
                e  = b | (t & ~d);
                ef = (32'(t | b) << i) | (32'(b) << (16 + i));
                bus_rd(12'h010, r); chk("R3 done flag", r, 32'hFFFF_0000 | (32'(d) << i));
                bus_rd(12'h020, r); chk("R4 fault reg", r, ef);
                chk("R5 err_vec", {16'b0, err_vec}, 32'(e) << i);
                chk("R6 irq", {31'b0, irq}, {31'b0, d | e});
                chk("R7 irq_src", {27'b0, irq_src}, e ? 32'(16 + i) : (d ? 32'(i) : 0));
            end
        end

        // R7 errors outrank completions
        bus_wr(12'h010, 32'hFFFF_0000);
        bus_wr(12'h028, 32'hFFFF_FFFF);
        pulse(16'h8008, 16'h0004, 0, 0);
        chk("R7 error first", {27'b0, irq_src}, 18);
        bus_wr(12'h028, 32'h0000_0004);
        chk("R7 highest completion", {27'b0, irq_src}, 15);
        bus_wr(12'h018, 32'h0000_8008);
        chk("R6 all acknowledged", {31'b0, irq}, 0);

        // R8 R9 control register
        bus_wr(12'h034, 32'h0003_0005);
        bus_rd(12'h030, r); chk("R8 ctrl read", r, 32'h0003_0005);
        chk("R8 freeze", {16'b0, freeze}, 5);
        chk("R8 reset", {16'b0, chan_reset}, 3);
        @(negedge clk); chan_idle = 16'h0001;
        @(negedge clk); chan_idle = '0;
        chk("R9 self clear", {16'b0, chan_reset}, 2);
        chk("R9 freeze kept", {16'b0, freeze}, 5);
        bus_wr(12'h038, 32'h5);
        chk("R8 freeze clear", {16'b0, freeze}, 0);
        bus_wr(12'h030, 32'h0);
        chk("R8 base write", {16'b0, chan_reset}, 0);

        // R10 R11 R12 per-channel pointer and semaphore
        for (int i = 0; i < NCH; i++) begin
            logic [11:0] pa, sa;
            logic [31:0] pv;
            pa = 12'(32'h110 + i * 32'h70);
            sa = 12'(32'h140 + i * 32'h70);
            pv = 32'hA000_0000 + i * 32'h1111;
            bus_wr(pa, pv);
            bus_rd(pa, r); chk("R10 ptr read", r, pv);
            chk("R10 ptr out", cmd_ptr[32*i +: 32], pv);
            bus_wr(sa, 32'hFFFF_FF03);
            bus_rd(sa, r); chk("R11 sem add", r, 3);
            chk("R11 run", {16'b0, run}, 32'(1) << i);
            pulse(0, 0, 0, 16'(1) << i);
            bus_rd(sa, r); chk("R11 sem dec", r, 2);
            bus_wr(sa, 250);
            bus_rd(sa, r); chk("R11 sem sum", r, 252);
            bus_wr(sa, 10);
            bus_rd(sa, r); chk("R11 sem saturate", r, 255);
            bus_wr(12'h034, 32'(1) << (16 + i));
            @(negedge clk);
            bus_rd(sa, r); chk("R12 sem cleared", r, 0);
            chk("R12 run low", {16'b0, run}, 0);
            bus_wr(sa, 5);
            bus_rd(sa, r); chk("R12 write ignored", r, 0);
            @(negedge clk); chan_idle = 16'(1) << i;
            @(negedge clk); chan_idle = '0;
            chk("R9 reset released", {16'b0, chan_reset}, 0);
            pulse(0, 0, 0, 16'(1) << i);
            bus_rd(sa, r); chk("R11 dec at zero", r, 0);
            bus_rd(pa, r); chk("R10 ptr kept", r, pv);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule